// File: doc/BRIEF.md
# Microwire Serial Master Engine

This block is a serial master for the half-duplex Microwire frame format. Software-side logic writes 8-bit command words into a shallow transmit queue. Each queued command opens a frame. The engine lowers an active-low frame select and shifts the command out MSB first, with data changing on falling serial-clock edges. It leaves one serial-clock period idle so the slave can decode the command. It then samples a response of 4 to 16 bits on rising serial-clock edges. The response is right-aligned, zero-extended and placed in a receive queue.

The serial clock comes from the system clock. Its half period is a programmable number of system clocks, so the divider is always even. When continuous mode is on and another command is already waiting, frame select stays low. The next command's MSB then follows straight after the response LSB. Otherwise the frame closes one serial-clock period after the last sample. A busy flag covers every frame. A sticky overrun flag records a response that was dropped because the receive queue was full.

Top module: `mw_master`

## Requirements
- R1: While frame select (`fss_n_o`) is high, `sclk_o` is low, `txd_o` is low, `txoe_n_o` is high and `busy_o` is low.
- R2: A command in the transmit queue starts a frame when the engine is idle. Frame select falls, `busy_o` goes high and the oldest command's bit 7 appears on `txd_o` in that same cycle.
- R3: The 8 command bits go out MSB first. Each bit is stable across a rising `sclk_o` edge and changes only at falling edges. `txoe_n_o` is low during all 8 command periods.
- R4: The ninth serial-clock period is a turnaround. During it and the whole response phase, `txd_o` is low and `txoe_n_o` is high.
- R5: The response length is `rx_len_i` clamped to 4..16 and taken at frame start. Response bits are sampled from `rxd_i` on rising `sclk_o` edges, MSB first. The word is stored in bits [N-1:0] with zeros above. A frame therefore has 9+N rising edges.
- R6: For a frame that does not chain, frame select rises 2×H system clocks after the last rising `sclk_o` edge, where H is the half period. The response word is then in the receive queue.
- R7: With `cont_i` high and a command waiting at the falling edge that ends a response, frame select stays low. The next command's MSB is on `txd_o` at that edge, and rising edges continue.
- R8: With `cont_i` high and the transmit queue empty at the end of a response, the frame closes exactly as in R6.
- R9: Each high or low half of `sclk_o` lasts H = `half_i` system clocks, with 0 treated as 1.
- R10: A response completing while the receive queue is full is discarded and sets `overrun_o`, which stays high until reset.
- R11: A command written while `tx_full_o` is high is ignored. Responses are read back in arrival order through `rx_data_o`/`rx_rd_i`, and `rx_empty_o` reports an empty queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| half_i | input | 8 | Serial clock half period in system clocks (0 acts as 1) |
| rx_len_i | input | 5 | Response length in bits, clamped to 4..16 |
| cont_i | input | 1 | Continuous (back-to-back) frame mode |
| tx_wr_i | input | 1 | Write strobe for the command queue |
| tx_data_i | input | 8 | Command word to queue |
| tx_full_o | output | 1 | Command queue full |
| rx_rd_i | input | 1 | Pop strobe for the response queue |
| rx_data_o | output | 16 | Oldest response word |
| rx_empty_o | output | 1 | Response queue empty |
| sclk_o | output | 1 | Serial clock |
| fss_n_o | output | 1 | Active-low frame select |
| txd_o | output | 1 | Serial transmit data |
| txoe_n_o | output | 1 | Active-low transmit pad enable |
| rxd_i | input | 1 | Serial receive data |
| busy_o | output | 1 | Frame in progress |
| overrun_o | output | 1 | Sticky response-dropped flag |

## Verification
The bench acts as the slave. It drives each response bit on the falling edge after the turnaround and measures every half period, including the degenerate setting where 0 acts as 1. An engine that samples during the turnaround, or skips it, shifts every response by one bit. Wrong clamping of out-of-range lengths, such as a request for 2 bits, shows up as a wrong rising-edge count and a misaligned word. The bench also fills the command queue until a write bounces and chains five frames into a four-deep response queue. An engine that drops frame select between chained frames, or mishandles a full queue, then shows a spurious frame-select rise, a missing command, a stored fifth word or a missing overrun flag.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int CMD_BITS = 8;
  localparam int RESP_MIN = 4;
  localparam int RESP_MAX = 16;
  localparam int LEN_W    = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_TAIL  = 2'd2
  } mw_state_e;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
    if (v < LEN_W'(RESP_MIN))      return LEN_W'(RESP_MIN);
    else if (v > LEN_W'(RESP_MAX)) return LEN_W'(RESP_MAX);
    else                           return v;
  endfunction
endpackage

// File: rtl/mw_fifo.sv
module mw_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem_q[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end
endmodule

// File: rtl/mw_clkgen.sv
module mw_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             step_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, limit;

  assign limit  = (half_i == '0) ? '0 : half_i - 1'b1;
  assign step_o = en_i & (cnt_q == limit);

  always_comb begin
    if (!en_i || step_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
#(
  parameter int RW = RESP_MAX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             cont_i,
  input  logic [LEN_W-1:0] rx_len_i,
  input  logic             tx_empty_i,
  input  logic [CMD_BITS-1:0] tx_word_i,
  input  logic             rxd_i,
  input  logic             rx_full_i,
  output logic             run_o,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [RW-1:0]    rx_word_o,
  output logic             overrun_o,
  output logic             sclk_o,
  output logic             fss_n_o,
  output logic             txd_o,
  output logic             txoe_n_o,
  output logic             busy_o
);
  localparam logic [LEN_W-1:0] TURN_IDX = LEN_W'(CMD_BITS);

  mw_state_e            st_q, st_d;
  logic                 ph_q, ph_d;
  logic [LEN_W-1:0]     idx_q, idx_d;
  logic [LEN_W-1:0]     last_q, last_d;
  logic [CMD_BITS-1:0]  tsh_q, tsh_d;
  logic [RW-1:0]        rsh_q, rsh_d;
  logic                 ovr_q, ovr_d;
  logic                 in_cmd;

  assign in_cmd = (st_q == ST_FRAME) && (idx_q < TURN_IDX);

  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    idx_d     = idx_q;
    last_d    = last_q;
    tsh_d     = tsh_q;
    rsh_d     = rsh_q;
    tx_pop_o  = 1'b0;
    rx_push_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (!tx_empty_i) begin
          st_d     = ST_FRAME;
          tx_pop_o = 1'b1;
          tsh_d    = tx_word_i;
          idx_d    = '0;
          ph_d     = 1'b0;
          rsh_d    = '0;
          last_d   = TURN_IDX + clamp_len(rx_len_i);
        end
      end
      ST_FRAME: begin
        if (step_i) begin
          if (!ph_q) begin
            ph_d = 1'b1;
            if (idx_q > TURN_IDX) rsh_d = {rsh_q[RW-2:0], rxd_i};
          end else begin
            ph_d = 1'b0;
            if (idx_q == last_q) begin
              if (cont_i && !tx_empty_i) begin
                rx_push_o = 1'b1;
                tx_pop_o  = 1'b1;
                tsh_d     = tx_word_i;
                idx_d     = '0;
                rsh_d     = '0;
                last_d    = TURN_IDX + clamp_len(rx_len_i);
              end else begin
                st_d = ST_TAIL;
              end
            end else begin
              idx_d = idx_q + 1'b1;
              if (idx_q < TURN_IDX) tsh_d = {tsh_q[CMD_BITS-2:0], 1'b0};
            end
          end
        end
      end
      ST_TAIL: begin
        if (step_i) begin
          rx_push_o = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    ovr_d = ovr_q | (rx_push_o & rx_full_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      tsh_q  <= '0;
      rsh_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      tsh_q  <= tsh_d;
      rsh_q  <= rsh_d;
      ovr_q  <= ovr_d;
    end
  end

  assign run_o     = (st_q != ST_IDLE);
  assign rx_word_o = rsh_q;
  assign overrun_o = ovr_q;
  assign sclk_o    = (st_q == ST_FRAME) & ph_q;
  assign fss_n_o   = (st_q == ST_IDLE);
  assign busy_o    = (st_q != ST_IDLE);
  assign txd_o     = in_cmd & tsh_q[CMD_BITS-1];
  assign txoe_n_o  = ~in_cmd;
endmodule

// File: rtl/mw_master.sv
module mw_master
  import mw_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DIV_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DIV_W-1:0]    half_i,
  input  logic [LEN_W-1:0]    rx_len_i,
  input  logic                cont_i,
  input  logic                tx_wr_i,
  input  logic [CMD_BITS-1:0] tx_data_i,
  output logic                tx_full_o,
  input  logic                rx_rd_i,
  output logic [RESP_MAX-1:0] rx_data_o,
  output logic                rx_empty_o,
  output logic                sclk_o,
  output logic                fss_n_o,
  output logic                txd_o,
  output logic                txoe_n_o,
  input  logic                rxd_i,
  output logic                busy_o,
  output logic                overrun_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic                tx_empty, tx_pop, rx_push, rx_full, run, step;
  logic [CMD_BITS-1:0] tx_word;
  logic [RESP_MAX-1:0] rx_word;

  mw_fifo #(.WIDTH(CMD_BITS), .DEPTH(DEPTH)) u_txq (
    .clk_i(clk_i), .rst_ni(rst_n), .push_i(tx_wr_i), .data_i(tx_data_i),
    .pop_i(tx_pop), .data_o(tx_word), .full_o(tx_full_o), .empty_o(tx_empty)
  );

  mw_fifo #(.WIDTH(RESP_MAX), .DEPTH(DEPTH)) u_rxq (
    .clk_i(clk_i), .rst_ni(rst_n), .push_i(rx_push), .data_i(rx_word),
    .pop_i(rx_rd_i), .data_o(rx_data_o), .full_o(rx_full), .empty_o(rx_empty_o)
  );

  mw_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(run), .half_i(half_i), .step_o(step)
  );

  mw_seq #(.RW(RESP_MAX)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_n), .step_i(step), .cont_i(cont_i),
    .rx_len_i(rx_len_i), .tx_empty_i(tx_empty), .tx_word_i(tx_word),
    .rxd_i(rxd_i), .rx_full_i(rx_full), .run_o(run), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_word_o(rx_word), .overrun_o(overrun_o),
    .sclk_o(sclk_o), .fss_n_o(fss_n_o), .txd_o(txd_o), .txoe_n_o(txoe_n_o),
    .busy_o(busy_o)
  );
endmodule

// File: rtl/mw_master_chk.sv
module mw_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic fss_n_o,
  input logic txd_o,
  input logic txoe_n_o,
  input logic overrun_o
);
  a_r1_idle_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fss_n_o |-> (!sclk_o && !txd_o && txoe_n_o));

  a_r3_oe_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fss_n_o) |-> !txoe_n_o);

  a_r3_txd_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(txd_o));

  a_r9_sclk_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !fss_n_o);

  a_r10_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  a_r4_no_data_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txoe_n_o |-> !txd_o);
endmodule

bind mw_master mw_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_o(sclk_o), .fss_n_o(fss_n_o),
  .txd_o(txd_o), .txoe_n_o(txoe_n_o), .overrun_o(overrun_o)
);

// File: tb/mw_master_bench.sv
`timescale 1ns/1ps
module mw_master_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [7:0]  half_i;
  logic [4:0]  rx_len_i;
  logic        cont_i, tx_wr_i, rx_rd_i, rxd_i;
  logic [7:0]  tx_data_i;
  logic        tx_full_o, rx_empty_o, sclk_o, fss_n_o, txd_o, txoe_n_o, busy_o, overrun_o;
  logic [15:0] rx_data_o;

  always #5 clk = ~clk;

  mw_master u_mw_master (
    .clk_i(clk), .rst_ni(rst_ni), .half_i(half_i), .rx_len_i(rx_len_i),
    .cont_i(cont_i), .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i), .tx_full_o(tx_full_o),
    .rx_rd_i(rx_rd_i), .rx_data_o(rx_data_o), .rx_empty_o(rx_empty_o),
    .sclk_o(sclk_o), .fss_n_o(fss_n_o), .txd_o(txd_o), .txoe_n_o(txoe_n_o),
    .rxd_i(rxd_i), .busy_o(busy_o), .overrun_o(overrun_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_edge = 0, last_rise = 0, r = 0, n_cur = 4, model_rx = 0, wd = 0;
  bit pending_end = 0, exp_ovr = 0, live = 0, done = 0;
  logic prev_sclk = 0, prev_fss = 1;
  logic [7:0]  cmd_bits;
  logic [15:0] resp;
  logic [7:0]  exp_cmd[$];
  logic [15:0] exp_rx[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int clampn(input int v);
    if (v < 4) return 4;
    if (v > 16) return 16;
    return v;
  endfunction

  function automatic int heff();
    return (half_i == 0) ? 1 : int'(half_i);
  endfunction

  function automatic logic [15:0] mkresp(input logic [7:0] c, input int n);
    logic [16:0] m;
    m = (17'd1 << n) - 17'd1;
    return {c, c ^ 8'h3C} & m[15:0];
  endfunction

  task automatic start_frame(input string req);
    r = 0;
    cmd_bits = '0;
    n_cur = clampn(int'(rx_len_i));
    last_edge = cyc;
    if (exp_cmd.size() == 0) begin
      chk(0, req, 1, 0);
      resp = '0;
    end else begin
      resp = mkresp(exp_cmd[0], n_cur);
      chk(txd_o == exp_cmd[0][7], req, txd_o, exp_cmd[0][7]);
    end
  endtask

  // slave model and per-cycle reference checks
  always @(negedge clk) begin
    cyc++;
    if (live) begin
      if (fss_n_o) chk(!sclk_o && !txd_o && txoe_n_o && !busy_o, "R1",
                       {sclk_o, txd_o, txoe_n_o, busy_o}, 4'b0010);
      else chk(busy_o, "R2", busy_o, 1);
      if (prev_fss && !fss_n_o) begin
        chk(!sclk_o, "R2", sclk_o, 0);
        start_frame("R2");
      end else if (!prev_fss && fss_n_o) begin
        chk(pending_end, cont_i ? "R8" : "R6", pending_end, 1);
        chk(cyc - last_rise == 2 * heff(), cont_i ? "R8" : "R6", cyc - last_rise, 2 * heff());
        pending_end = 0;
      end else if (!prev_sclk && sclk_o) begin
        chk(cyc - last_edge == heff(), "R9", cyc - last_edge, heff());
        last_edge = cyc;
        last_rise = cyc;
        r++;
        if (r <= 8) begin
          chk(!txoe_n_o, "R3", txoe_n_o, 0);
          cmd_bits = {cmd_bits[6:0], txd_o};
          if (r == 8) begin
            if (exp_cmd.size() > 0) begin
              chk(cmd_bits == exp_cmd[0], "R3", cmd_bits, exp_cmd[0]);
              void'(exp_cmd.pop_front());
            end
          end
        end else begin
          chk(txoe_n_o && !txd_o, "R4", {txoe_n_o, txd_o}, 2'b10);
        end
        chk(r <= 9 + n_cur, "R5", r, 9 + n_cur);
      end else if (prev_sclk && !sclk_o) begin
        chk(cyc - last_edge == heff(), "R9", cyc - last_edge, heff());
        last_edge = cyc;
        if (r >= 9 && r < 9 + n_cur) rxd_i = resp[n_cur - 1 - (r - 9)];
        if (r == 9 + n_cur) begin
          if (model_rx < 4) begin
            exp_rx.push_back(resp);
            model_rx++;
          end else exp_ovr = 1;
          if (cont_i && exp_cmd.size() > 0) begin
            chk(!fss_n_o, "R7", fss_n_o, 0);
            start_frame("R7");
          end else pending_end = 1;
        end
      end
    end
    prev_sclk = sclk_o;
    prev_fss  = fss_n_o;
  end

  task automatic wr_burst(input int n, input logic [7:0] base, input int full_at);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (full_at >= 0) chk(tx_full_o == (i == full_at), "R11", tx_full_o, i == full_at);
      if (!tx_full_o) exp_cmd.push_back(base + 8'(i * 37));
      tx_wr_i = 1'b1;
      tx_data_i = base + 8'(i * 37);
    end
    @(negedge clk);
    tx_wr_i = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 30) begin
      @(negedge clk);
      quiet = fss_n_o ? quiet + 1 : 0;
    end
    chk(exp_cmd.size() == 0, "R2", exp_cmd.size(), 0);
    chk(!pending_end, "R6", pending_end, 0);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!rx_empty_o, "R11", rx_empty_o, 0);
      if (exp_rx.size() > 0) begin
        chk(rx_data_o == exp_rx[0], "R5", rx_data_o, exp_rx[0]);
        void'(exp_rx.pop_front());
        model_rx--;
      end
      rx_rd_i = 1'b1;
      @(negedge clk);
      rx_rd_i = 1'b0;
    end
    @(negedge clk);
    chk(rx_empty_o == (exp_rx.size() == 0), "R11", rx_empty_o, exp_rx.size() == 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      chk(0, "watchdog", wd, 150000);
      finish_run();
    end
  end

  initial begin
    rst_ni = 1'b0; half_i = 8'd2; rx_len_i = 5'd8; cont_i = 1'b0;
    tx_wr_i = 1'b0; tx_data_i = '0; rx_rd_i = 1'b0; rxd_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(fss_n_o && !sclk_o && !txd_o && txoe_n_o && !busy_o, "R1",
        {fss_n_o, sclk_o, txd_o, txoe_n_o, busy_o}, 5'b10010);
    chk(!tx_full_o && rx_empty_o && !overrun_o, "R11",
        {tx_full_o, rx_empty_o, overrun_o}, 3'b010);
    live = 1;

    // single frame, 8-bit response, H=2
    wr_burst(1, 8'hA5, -1);
    wait_idle();
    drain(1);

    // H=0 acts as 1; length 2 clamps to 4; two separate single frames
    half_i = 8'd0; rx_len_i = 5'd2;
    wr_burst(2, 8'h3C, -1);
    wait_idle();
    drain(2);

    // continuous chaining, 16-bit response, H=3
    half_i = 8'd3; rx_len_i = 5'd16; cont_i = 1'b1;
    wr_burst(3, 8'h81, -1);
    wait_idle();
    drain(3);

    // continuous mode with nothing queued closes as single (R8); length 25 clamps to 16
    rx_len_i = 5'd25; half_i = 8'd1;
    wr_burst(1, 8'h5A, -1);
    wait_idle();
    drain(1);
    chk(!overrun_o, "R10", overrun_o, 0);

    // burst of six: sixth bounces (R11), five chained frames overrun the response queue (R10)
    rx_len_i = 5'd13;
    wr_burst(6, 8'h17, 5);
    wait_idle();
    chk(overrun_o == exp_ovr && exp_ovr, "R10", overrun_o, 1);
    drain(4);
    chk(overrun_o, "R10", overrun_o, 1);

    finish_run();
  end
endmodule